// File: doc/BRIEF.md
# Set/Clear Action GPIO Register Pair

This block gives software race-free control of a group of general-purpose pins through write-one action registers. Each register word controls up to eight pins. A write never stores the word. Every 1 in it is a one-shot command for one pin: pull its output latch low, push it high, make it an output, or make it an input. Two agents can therefore update different pins of the same register without a read-modify-write and without a lock.

Two banks are built from one bank module. The first serves eight pins at byte offset 0x188. The second serves four pins at offset 0x18C and takes the next four pin indices. A read of a bank address returns the synchronized pad levels of that bank's pins. Each level sits in the odd bit of the pin's two-bit slot. Software sets the level of a pin before it writes the output command, so the pad never shows a stale value when the driver turns on.

The register bus is a plain single-cycle interface (address, write strobe, write word, read word), so no valid/ready handshake or back-pressure applies. Writes take effect on the clock edge where `bus_wr_en` is high. Read data is combinational from the address.

Top module: `setclr_gpio`

## Requirements
- R1: A write to a bank with bit 2n set and bit 2n+1 clear drives pin n's output latch low from the next clock edge.
- R2: A write with bit 2n+1 set and bit 2n clear drives pin n's output latch high from the next clock edge.
- R3: A write with bit 16+2n set and bit 17+2n clear makes pin n an output (its output enable goes high).
- R4: A write with bit 17+2n set and bit 16+2n clear makes pin n an input (its output enable goes low).
- R5: When both level bits of a pin are set in one write, its latch keeps its value. When both direction bits are set in one write, its direction keeps its value.
- R6: Bits written as 0 change nothing. A write to any address other than the two bank offsets changes no pin.
- R7: A read of a bank returns, in bit 2n+1, the level of that bank's pin n after a two-flop synchronizer, visible after the second clock edge. All other bits read 0. Reads of other addresses return 0.
- R8: After reset all pins are inputs (output enable 0) with output latches low.
- R9: Action bits for pin slots at or beyond a bank's pin count are ignored.
- R10: Bank 0 sits at byte offset 0x188 and drives pins 0 to 7. Bank 1 sits at 0x18C and drives pins 8 to 11 as its local pins 0 to 3.
- R11: A level written while a pin is an input updates `pin_out` but leaves `pin_oe` low, so a later output command drives the level already set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wr_en | input | 1 | Write strobe, one write per high cycle |
| bus_wdata | input | 32 | Action word |
| bus_rdata | output | 32 | Readback word of the addressed bank |
| pin_in | input | 12 | Pad input levels, asynchronous |
| pin_out | output | 12 | Output latch value per pin |
| pin_oe | output | 12 | Output enable per pin |

## Verification
Every pin slot of both banks, including the unused slots of the 4-pin bank, is written with all sixteen combinations of its two level bits and two direction bits. A running model is compared after each write. This separates the single-command cases from the tie cases and shows that commands affect only the addressed pin. Pseudo-random action words, sent to both bank addresses and to neighbouring addresses, test that each pin decodes its own slot and that stray addresses are ignored. All 4096 pad input patterns are read back through both banks, which exposes any bit-placement error or crossed bank.

// File: rtl/sgpio_pkg.sv
package sgpio_pkg;
  localparam int REG_W     = 32;
  localparam int MAX_PINS  = 8;
  localparam int DIR_FIELD = 16;

  typedef struct packed {
    logic drv_lo;
    logic drv_hi;
    logic mk_out;
    logic mk_in;
  } pin_act_t;

  // Extract the four action bits that belong to pin slot n.
  function automatic pin_act_t slot_actions(input logic [REG_W-1:0] w, input int n);
    pin_act_t a;
    a.drv_lo = w[2*n];
    a.drv_hi = w[2*n+1];
    a.mk_out = w[DIR_FIELD+2*n];
    a.mk_in  = w[DIR_FIELD+2*n+1];
    return a;
  endfunction
endpackage

// File: rtl/sgpio_sync.sv
module sgpio_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
    end
  end

  assign sync_o = sync_q;
endmodule

// File: rtl/sgpio_pin.sv
module sgpio_pin
  import sgpio_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     act_vld,
  input  pin_act_t act,
  output logic     lvl_o,
  output logic     oe_o
);
  logic lvl_q;
  logic oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      oe_q  <= 1'b0;
    end else if (act_vld) begin
      if (act.drv_lo ^ act.drv_hi) lvl_q <= act.drv_hi;
      if (act.mk_out ^ act.mk_in)  oe_q  <= act.mk_out;
    end
  end

  assign lvl_o = lvl_q;
  assign oe_o  = oe_q;

  // R1
  drive_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_vld && act.drv_lo && !act.drv_hi |=> !lvl_o);
  // R2
  drive_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_vld && act.drv_hi && !act.drv_lo |=> lvl_o);
  // R3
  make_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_vld && act.mk_out && !act.mk_in |=> oe_o);
  // R4
  make_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_vld && act.mk_in && !act.mk_out |=> !oe_o);
  // R5
  tie_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_vld || ((act.drv_lo == act.drv_hi) && (act.mk_out == act.mk_in)))
      |=> $stable(lvl_o) && $stable(oe_o));
endmodule

// File: rtl/sgpio_bank.sv
module sgpio_bank
  import sgpio_pkg::*;
#(
  parameter int              PINS   = 8,
  parameter int              ADDR_W = 12,
  parameter logic [ADDR_W-1:0] OFS  = 12'h188
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic [PINS-1:0]   pad_i,
  output logic [PINS-1:0]   lvl_o,
  output logic [PINS-1:0]   oe_o,
  output logic              hit_o,
  output logic [REG_W-1:0]  rword_o
);
  localparam int SLOT_BITS = 2 * PINS;

  // Write bits that address a pin that exists in this bank.
  localparam logic [REG_W-1:0] LIVE_MASK =
    (REG_W'((64'(1) << SLOT_BITS) - 1)) |
    (REG_W'((64'(1) << SLOT_BITS) - 1) << DIR_FIELD);

  logic            wr_hit;
  logic [PINS-1:0] pad_sync;

  assign hit_o  = (addr_i == OFS);
  assign wr_hit = wr_en_i && hit_o;

  sgpio_sync #(.W(PINS)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (pad_i),
    .sync_o  (pad_sync)
  );

  for (genvar n = 0; n < PINS; n++) begin : g_pin
    sgpio_pin u_pin (
      .clk     (clk),
      .rst_n   (rst_n),
      .act_vld (wr_hit),
      .act     (slot_actions(wdata_i, n)),
      .lvl_o   (lvl_o[n]),
      .oe_o    (oe_o[n])
    );
  end

  always_comb begin
    rword_o = '0;
    for (int n = 0; n < PINS; n++) rword_o[2*n+1] = pad_sync[n];
  end

  // R9
  dead_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit && ((wdata_i & LIVE_MASK) == '0) |=> $stable(lvl_o) && $stable(oe_o));
endmodule

// File: rtl/setclr_gpio.sv
module setclr_gpio
  import sgpio_pkg::*;
#(
  parameter int              ADDR_W     = 12,
  parameter int              BANK0_PINS = 8,
  parameter int              BANK1_PINS = 4,
  parameter logic [ADDR_W-1:0] BANK0_OFS = 12'h188,
  parameter logic [ADDR_W-1:0] BANK1_OFS = 12'h18C,
  localparam int             NPINS      = BANK0_PINS + BANK1_PINS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr_en,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe
);
  localparam int NB = 2;
  localparam int BANK_PINS [NB] = '{BANK0_PINS, BANK1_PINS};
  localparam int BANK_BASE [NB] = '{0, BANK0_PINS};
  localparam logic [ADDR_W-1:0] BANK_OFS [NB] = '{BANK0_OFS, BANK1_OFS};

  logic [NB-1:0]    hit;
  logic [REG_W-1:0] rword [NB];

  for (genvar b = 0; b < NB; b++) begin : g_bank
    sgpio_bank #(
      .PINS   (BANK_PINS[b]),
      .ADDR_W (ADDR_W),
      .OFS    (BANK_OFS[b])
    ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .addr_i  (bus_addr),
      .wr_en_i (bus_wr_en),
      .wdata_i (bus_wdata),
      .pad_i   (pin_in[BANK_BASE[b] +: BANK_PINS[b]]),
      .lvl_o   (pin_out[BANK_BASE[b] +: BANK_PINS[b]]),
      .oe_o    (pin_oe[BANK_BASE[b] +: BANK_PINS[b]]),
      .hit_o   (hit[b]),
      .rword_o (rword[b])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int b = 0; b < NB; b++) if (hit[b]) bus_rdata |= rword[b];
  end

  // R6
  stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr_en && (bus_addr != BANK0_OFS) && (bus_addr != BANK1_OFS)
      |=> $stable(pin_out) && $stable(pin_oe));
  // R7
  stray_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr != BANK0_OFS) && (bus_addr != BANK1_OFS) |-> bus_rdata == '0);
endmodule

// File: tb/tb_setclr_gpio.sv
module tb_setclr_gpio;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr_en = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [11:0] pin_in = '0;
  logic [11:0] pin_out;
  logic [11:0] pin_oe;

  int tests = 0;
  int fails = 0;
  logic [11:0] m_out = '0;
  logic [11:0] m_oe  = '0;
  logic [31:0] lcg = 32'h1234_5678;

  always #4 clk = ~clk;

  setclr_gpio dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  function automatic int bank_pins(input int b);
    return (b == 0) ? 8 : 4;
  endfunction
  function automatic int bank_base(input int b);
    return (b == 0) ? 0 : 8;
  endfunction
  function automatic logic [11:0] bank_addr(input int b);
    return (b == 0) ? 12'h188 : 12'h18C;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // Requirement model of one write (R1..R6, R9, R10).
  task automatic model_write(input logic [11:0] a, input logic [31:0] w);
    for (int b = 0; b < 2; b++) begin
      if (a == bank_addr(b)) begin
        for (int n = 0; n < bank_pins(b); n++) begin
          int p = bank_base(b) + n;
          if (w[2*n] != w[2*n+1]) m_out[p] = w[2*n+1];
          if (w[16+2*n] != w[17+2*n]) m_oe[p] = w[16+2*n];
        end
      end
    end
  endtask

  task automatic do_write(input string req, input logic [11:0] a, input logic [31:0] w);
    @(negedge clk);
    bus_addr = a; bus_wdata = w; bus_wr_en = 1'b1;
    @(negedge clk);
    bus_wr_en = 1'b0;
    model_write(a, w);
    check({req, " pin_out"}, {20'b0, pin_out}, {20'b0, m_out});
    check({req, " pin_oe"},  {20'b0, pin_oe},  {20'b0, m_oe});
  endtask

  function automatic logic [31:0] read_model(input logic [11:0] a, input logic [11:0] pins);
    logic [31:0] r = '0;
    for (int b = 0; b < 2; b++)
      if (a == bank_addr(b))
        for (int n = 0; n < bank_pins(b); n++) r[2*n+1] = pins[bank_base(b)+n];
    return r;
  endfunction

  initial begin : watchdog
    #(8 * 150000);
    fails++;
    tests++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R8: reset state
    check("R8 pin_out after reset", {20'b0, pin_out}, 32'h0);
    check("R8 pin_oe after reset",  {20'b0, pin_oe},  32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 pin_oe after release", {20'b0, pin_oe}, 32'h0);

    // R11: level first while input, then direction
    do_write("R11 level while input", 12'h188, 32'h0000_0008);
    check("R11 pin_out bit1 set", {31'b0, pin_out[1]}, 32'h1);
    check("R11 pin_oe stays low", {31'b0, pin_oe[1]}, 32'h0);
    do_write("R11 then output", 12'h188, 32'h0004_0000);
    check("R11 pin1 driven high", {30'b0, pin_oe[1], pin_out[1]}, 32'h3);

    // R1 R2 R3 R4 R5 R9 R10: every slot, every command combination
    for (int b = 0; b < 2; b++)
      for (int n = 0; n < 8; n++)
        for (int c = 0; c < 16; c++) begin
          logic [31:0] w = '0;
          w[2*n]    = c[0];
          w[2*n+1]  = c[1];
          w[16+2*n] = c[2];
          w[17+2*n] = c[3];
          if (n < bank_pins(b)) do_write("R1 R2 R3 R4 R5 R10 slot sweep", bank_addr(b), w);
          else                  do_write("R9 dead slot sweep", bank_addr(b), w);
        end

    // R6 R10: pseudo-random words at bank and neighbouring addresses
    for (int k = 0; k < 300; k++) begin
      logic [11:0] a;
      lcg = lcg * 32'd1103515245 + 32'd12345;
      case (lcg[1:0])
        2'd0: a = 12'h188;
        2'd1: a = 12'h18C;
        2'd2: a = 12'h189;
        default: a = 12'h190;
      endcase
      do_write("R6 R10 random word", a, {lcg[15:0] ^ lcg[31:16], lcg[31:16]});
    end
    do_write("R6 zero word", 12'h188, 32'h0);
    do_write("R6 zero word", 12'h18C, 32'h0);

    // R7: all pad patterns read back through both banks
    for (int v = 0; v < 4096; v++) begin
      @(negedge clk);
      pin_in = v[11:0];
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      bus_addr = 12'h188; #1;
      check("R7 bank0 readback", bus_rdata, read_model(12'h188, v[11:0]));
      bus_addr = 12'h18C; #1;
      check("R7 bank1 readback", bus_rdata, read_model(12'h18C, v[11:0]));
      if (v[7:0] == 8'hA5) begin
        bus_addr = 12'h184; #1;
        check("R7 stray address reads zero", bus_rdata, 32'h0);
      end
    end

    // R7: synchronizer latency, one edge is not enough
    @(negedge clk);
    pin_in = 12'h000;
    repeat (3) @(negedge clk);
    pin_in = 12'hFFF;
    @(posedge clk);
    @(negedge clk);
    bus_addr = 12'h188; #1;
    check("R7 not visible after one edge", bus_rdata, 32'h0);
    @(negedge clk); #1;
    check("R7 visible after two edges", bus_rdata, 32'hAAAA);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule